// File: doc/BRIEF.md
# EDO DRAM Page-Mode Access Controller

This block sits between a synchronous host port and an 8-bit extended-data-out asynchronous DRAM. It turns host read and write requests into row strobe, column strobe, write-enable and output-enable pulses. Each linear host address is split into a row part (upper bits) and a column part (lower bits), and both are driven on one shared address bus. After an access, the row is left open. A later request to the same row costs only a column cycle. A request to another row first closes the open row and then opens the new one.

All DRAM timing is set by parameters counted in clock cycles, rounded up from the device's nanosecond figures. The controller enforces several limits:
- the row-to-column delay;
- the column access window;
- a minimum row-active time and a minimum precharge time on every row change;
- a ceiling on how long a row may stay open.

A separate refresh scheduler asks for a refresh with a level request. The controller closes any open row, waits out precharge, pulses a grant and runs a column-before-row refresh cycle. A pending refresh always wins over a page hit.

Top module: `edo_page_ctrl`

## Requirements
- R1: During and straight after reset, `ras_n`, `cas_n`, `we_n` and `oe_n` are high (1), and `dq_oe`, `req_ready`, `rd_valid` and `ref_gnt` are low.
- R2: When `ras_n` falls for an access, `dram_addr` carries `req_addr[ROW_W+COL_W-1:COL_W]`. When `cas_n` falls, `dram_addr` carries `req_addr[COL_W-1:0]` (upper bus bits zero).
- R3: A read (`req_we`=0) holds `we_n`=1 and `oe_n`=0 while `cas_n` is low. It samples `dq_in` after `T_ACC` cycles of `cas_n` low. It returns the byte on `rd_data` with `rd_valid` high for exactly one cycle, in the same cycle as the single-cycle `req_ready` pulse.
- R4: A write (`req_we`=1) is an early write. `we_n` goes low at least one cycle before `cas_n` falls, `dq_oe`=1 carries `req_wdata`, and `oe_n` stays high. `req_ready` pulses once and `rd_valid` stays low.
- R5: A request whose row equals the open row completes with a column cycle only, with no `ras_n` transition.
- R6: A request to a different row raises `ras_n`, and lowers it again with the new row address before the column cycle.
- R7: Every `ras_n` low period lasts at least `T_RAS_MIN` cycles, even when a miss or refresh is waiting.
- R8: Every `ras_n` high period before a fall lasts at least `T_RP` cycles.
- R9: No `ras_n` low period exceeds `T_RAS_MAX` cycles. A row is closed before that limit even under a continuous stream of hits.
- R10: On `ref_req`, the controller precharges and pulses `ref_gnt` for one cycle. It then lowers `cas_n` at least one cycle before `ras_n` (refresh order) and raises both afterwards.
- R11: When `ref_req` and a page-hit request are both pending with a row open, the refresh is granted before the request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request pending; held until `req_ready` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Linear byte address, row in upper bits |
| req_wdata | input | DATA_W | Write byte |
| req_ready | output | 1 | One-cycle pulse: request finished |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds read byte |
| rd_data | output | DATA_W | Read byte |
| ref_req | input | 1 | Refresh wanted, held until `ref_gnt` |
| ref_gnt | output | 1 | One-cycle pulse: refresh cycle starting |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dq_out | output | DATA_W | Write data toward the DRAM |
| dq_oe | output | 1 | Drive enable for `dq_out` |
| dq_in | input | DATA_W | Read data from the DRAM |

## Verification
The embedded assertions check the strobe-level timing rules on every cycle:
- row-active minimum and ceiling, and precharge minimum;
- write-enable settling before the column strobe;
- column-before-row order in refresh;
- single-cycle shapes of the ready, read-valid and grant pulses.

Only the scenarios can show the rest: data stored at the right split address and returned intact, page hits that cost no row cycle, misses that reopen the row, forced closure under a long hit stream, and refresh winning over a pending hit. For this, the bench runs a small memory model driven by the strobes.

// File: rtl/edo_pkg.sv
package edo_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_COLSET,
    ST_CAS,
    ST_OPEN,
    ST_RCAS,
    ST_RRAS
  } edo_state_e;
endpackage

// File: rtl/edo_addr_split.sv
module edo_addr_split #(
  parameter int unsigned ROW_W = 13,
  parameter int unsigned COL_W = 10
) (
  input  logic [ROW_W+COL_W-1:0] addr,
  input  logic [ROW_W-1:0]       open_row,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic                   same_row
);
  assign row      = addr[ROW_W+COL_W-1:COL_W];
  assign col      = addr[COL_W-1:0];
  assign same_row = (row == open_row);
endmodule

// File: rtl/edo_phase_timer.sv
module edo_phase_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/edo_ras_guard.sv
module edo_ras_guard #(
  parameter int unsigned T_RAS_MIN = 3,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_RAS_MAX = 4500,
  parameter int unsigned AGE_LIM   = 4495
) (
  input  logic clk,
  input  logic rst,
  input  logic ras_n,
  output logic close_ok,
  output logic open_ok,
  output logic age_hit
);
  localparam int unsigned RW   = $clog2(T_RAS_MAX + 2);
  localparam int unsigned PW   = $clog2(T_RP + 1) + 1;
  localparam logic [RW-1:0] RSAT = RW'(T_RAS_MAX + 1);
  localparam logic [PW-1:0] PSAT = PW'(T_RP);

  logic [RW-1:0] low_cnt;
  logic [PW-1:0] high_cnt;

  // low_cnt holds (cycles low so far - 1) while ras_n is low
  always_ff @(posedge clk) begin
    if (rst) begin
      low_cnt  <= '0;
      high_cnt <= '0;
    end else if (!ras_n) begin
      if (low_cnt != RSAT) low_cnt <= low_cnt + 1'b1;
      high_cnt <= '0;
    end else begin
      low_cnt <= '0;
      if (high_cnt != PSAT) high_cnt <= high_cnt + 1'b1;
    end
  end

  assign close_ok = !ras_n && (low_cnt >= RW'(T_RAS_MIN - 1));
  assign open_ok  = ras_n && (high_cnt >= PW'(T_RP - 1));
  assign age_hit  = !ras_n && (low_cnt >= RW'(AGE_LIM));

  AST_RAS_MIN: assert property (@(posedge clk) disable iff (rst)
    $rose(ras_n) |-> low_cnt >= RW'(T_RAS_MIN)); // R7
  AST_RP_MIN: assert property (@(posedge clk) disable iff (rst)
    $fell(ras_n) |-> high_cnt >= PW'(T_RP)); // R8
  AST_RAS_MAX: assert property (@(posedge clk) disable iff (rst)
    low_cnt <= RW'(T_RAS_MAX)); // R9
endmodule

// File: rtl/edo_page_ctrl.sv
module edo_page_ctrl
  import edo_pkg::*;
#(
  parameter int unsigned ROW_W     = 13,
  parameter int unsigned COL_W     = 10,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned T_RCD     = 2,
  parameter int unsigned T_ACC     = 2,
  parameter int unsigned T_RAS_MIN = 3,
  parameter int unsigned T_RP      = 2,
  parameter int unsigned T_RAS_MAX = 4500
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  req_valid,
  input  logic                                  req_we,
  input  logic [ROW_W+COL_W-1:0]                req_addr,
  input  logic [DATA_W-1:0]                     req_wdata,
  output logic                                  req_ready,
  output logic                                  rd_valid,
  output logic [DATA_W-1:0]                     rd_data,
  input  logic                                  ref_req,
  output logic                                  ref_gnt,
  output logic                                  ras_n,
  output logic                                  cas_n,
  output logic                                  we_n,
  output logic                                  oe_n,
  output logic [(ROW_W>COL_W?ROW_W:COL_W)-1:0]  dram_addr,
  output logic [DATA_W-1:0]                     dq_out,
  output logic                                  dq_oe,
  input  logic [DATA_W-1:0]                     dq_in
);
  localparam int unsigned AW      = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int unsigned TMAX    = (T_RCD > T_ACC) ? T_RCD : T_ACC;
  localparam int unsigned TW      = $clog2(TMAX + 1);
  localparam int unsigned AGE_LIM = T_RAS_MAX - T_ACC - 3;

  edo_state_e state, nxt;

  logic [ROW_W-1:0]  req_row, open_row;
  logic [COL_W-1:0]  req_col, cur_col, eff_col;
  logic              same_row, cur_we, eff_we, take;
  logic [DATA_W-1:0] cur_wdata, eff_wdata;
  logic              ph_load, ph_done;
  logic [TW-1:0]     ph_val;
  logic              close_ok, open_ok, age_hit;
  logic              new_req, want_close;

  edo_addr_split #(.ROW_W(ROW_W), .COL_W(COL_W)) u_split (
    .addr(req_addr), .open_row(open_row),
    .row(req_row), .col(req_col), .same_row(same_row)
  );

  edo_phase_timer #(.W(TW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .done(ph_done)
  );

  edo_ras_guard #(
    .T_RAS_MIN(T_RAS_MIN), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX), .AGE_LIM(AGE_LIM)
  ) u_guard (
    .clk(clk), .rst(rst), .ras_n(ras_n),
    .close_ok(close_ok), .open_ok(open_ok), .age_hit(age_hit)
  );

  // a request already acknowledged this cycle is not taken again
  assign new_req    = req_valid && !req_ready;
  assign want_close = ref_req || age_hit || (new_req && !same_row);

  always_comb begin
    nxt     = state;
    take    = 1'b0;
    ph_load = 1'b0;
    ph_val  = '0;
    unique case (state)
      ST_IDLE: begin
        if (open_ok && ref_req) begin
          nxt = ST_RCAS;
        end else if (open_ok && new_req) begin
          nxt     = ST_ACT;
          take    = 1'b1;
          ph_load = 1'b1;
          ph_val  = TW'(T_RCD - 1);
        end
      end
      ST_ACT:    if (ph_done) nxt = ST_COLSET;
      ST_COLSET: begin
        nxt     = ST_CAS;
        ph_load = 1'b1;
        ph_val  = TW'(T_ACC - 1);
      end
      ST_CAS:    if (ph_done) nxt = ST_OPEN;
      ST_OPEN: begin
        if (want_close) begin
          if (close_ok) nxt = ST_IDLE;
        end else if (new_req) begin
          nxt  = ST_COLSET;
          take = 1'b1;
        end
      end
      ST_RCAS:   nxt = ST_RRAS;
      ST_RRAS:   if (close_ok) nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  assign eff_we    = take ? req_we    : cur_we;
  assign eff_col   = take ? req_col   : cur_col;
  assign eff_wdata = take ? req_wdata : cur_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      open_row  <= '0;
      cur_col   <= '0;
      cur_we    <= 1'b0;
      cur_wdata <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dram_addr <= '0;
      dq_out    <= '0;
      dq_oe     <= 1'b0;
      req_ready <= 1'b0;
      rd_valid  <= 1'b0;
      rd_data   <= '0;
      ref_gnt   <= 1'b0;
    end else begin
      state <= nxt;
      if (take) begin
        cur_col   <= req_col;
        cur_we    <= req_we;
        cur_wdata <= req_wdata;
        if (state == ST_IDLE) open_row <= req_row;
      end
      ras_n <= !(nxt inside {ST_ACT, ST_COLSET, ST_CAS, ST_OPEN, ST_RRAS});
      cas_n <= !(nxt inside {ST_CAS, ST_RCAS, ST_RRAS});
      we_n  <= !((nxt inside {ST_COLSET, ST_CAS}) && eff_we);
      oe_n  <= !((nxt == ST_CAS) && !eff_we);
      dq_oe <= (nxt inside {ST_COLSET, ST_CAS}) && eff_we;
      dq_out <= eff_wdata;
      if (nxt == ST_ACT && state != ST_ACT)
        dram_addr <= AW'(req_row);
      else if (nxt inside {ST_COLSET, ST_CAS})
        dram_addr <= AW'(eff_col);
      req_ready <= (state == ST_CAS) && ph_done;
      rd_valid  <= (state == ST_CAS) && ph_done && !cur_we;
      if ((state == ST_CAS) && ph_done && !cur_we) rd_data <= dq_in;
      ref_gnt <= (nxt == ST_RCAS) && (state != ST_RCAS);
    end
  end

  AST_RDV_PULSE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R3
  AST_RDV_READY: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> req_ready); // R3
  AST_EARLY_WE: assert property (@(posedge clk) disable iff (rst)
    ($fell(cas_n) && !we_n) |-> $past(!we_n)); // R4
  AST_WR_NO_OE: assert property (@(posedge clk) disable iff (rst)
    !we_n |-> oe_n); // R4
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && !cas_n) |-> $past(!cas_n)); // R10
  AST_GNT_PULSE: assert property (@(posedge clk) disable iff (rst)
    ref_gnt |=> !ref_gnt); // R10
endmodule

// File: tb/edo_page_ctrl_tb.sv
module edo_page_ctrl_tb;
  localparam int unsigned ROW_W = 4, COL_W = 3, DATA_W = 8;
  localparam int unsigned T_RCD = 2, T_ACC = 2, T_RAS_MIN = 8, T_RP = 3, T_RAS_MAX = 120;
  localparam int unsigned AW = 4;

  logic clk = 0, rst = 1;
  logic req_valid = 0, req_we = 0, ref_req = 0;
  logic [ROW_W+COL_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [DATA_W-1:0] rd_data, dq_out, dq_in;
  logic [AW-1:0] dram_addr;

  always #10 clk = ~clk;

  edo_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RCD(T_RCD),
    .T_ACC(T_ACC), .T_RAS_MIN(T_RAS_MIN), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .ref_req(ref_req), .ref_gnt(ref_gnt), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dram_addr(dram_addr), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model driven by strobes, observed at falling clock edges
  logic [DATA_W-1:0] mem [0:(1<<(ROW_W+COL_W))-1];
  logic [ROW_W-1:0] m_row = '0;
  logic [COL_W-1:0] m_col = '0;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  int ras_falls = 0, refreshes = 0, early_bad = 0, wr_oe_bad = 0, row_addr_bad = 0;
  int low_len = 0, high_len = 0, min_bad = 0, rp_bad = 0, max_bad = 0, max_low = 0;

  assign dq_in = (!cas_n && !oe_n) ? mem[{m_row, m_col}] : '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (p_ras && !ras_n) begin
        if (high_len < int'(T_RP)) rp_bad++;
        if (!cas_n) refreshes++;
        else begin
          ras_falls++;
          m_row = dram_addr[ROW_W-1:0];
          if (dram_addr[AW-1:ROW_W-1] != dram_addr[ROW_W-1:ROW_W-1]) row_addr_bad++;
        end
      end
      if (!p_ras && ras_n) begin
        if (low_len < int'(T_RAS_MIN)) min_bad++;
        if (low_len > int'(T_RAS_MAX)) max_bad++;
        if (low_len > max_low) max_low = low_len;
      end
      if (!ras_n && p_cas && !cas_n && !p_ras) begin
        m_col = dram_addr[COL_W-1:0];
        if (dram_addr[AW-1:COL_W] != '0) row_addr_bad++;
        if (!we_n) begin
          if (p_we) early_bad++;
          if (!dq_oe || !oe_n) wr_oe_bad++;
          mem[{m_row, m_col}] = dq_out;
        end
      end
      if (!ras_n) begin low_len++; high_len = 0; end
      else begin high_len++; low_len = 0; end
    end
    p_ras = ras_n; p_cas = cas_n; p_we = we_n;
  end

  task automatic access(input logic we, input int row, input int col, input logic [7:0] wd,
                        output logic [7:0] rd, output logic rv);
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = {ROW_W'(row), COL_W'(col)}; req_wdata = wd;
    do @(negedge clk); while (!req_ready);
    rd = rd_data; rv = rd_valid;
    req_valid = 0;
  endtask

  task automatic t_reset();
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !req_ready && !rd_valid && !ref_gnt, "R1 handshakes",
        {dq_oe, req_ready, rd_valid, ref_gnt}, 0);
  endtask

  task automatic t_write_read();
    logic [7:0] d; logic v;
    access(1, 3, 5, 8'hA5, d, v);
    chk(!v, "R4 write rd_valid", v, 0);
    chk(mem[{4'd3, 3'd5}] == 8'hA5, "R2 write lands at row3 col5", mem[{4'd3, 3'd5}], 8'hA5);
    chk(early_bad == 0 && wr_oe_bad == 0, "R4 early write", early_bad + wr_oe_bad, 0);
    access(0, 3, 5, 8'h00, d, v);
    chk(v, "R3 rd_valid with ready", v, 1);
    chk(d == 8'hA5, "R3 read data", d, 8'hA5);
    @(negedge clk);
    chk(!rd_valid && !req_ready, "R3 single-cycle pulse", {rd_valid, req_ready}, 0);
    chk(row_addr_bad == 0, "R2 bus upper bits", row_addr_bad, 0);
  endtask

  task automatic t_page_hit();
    logic [7:0] d; logic v; int r0;
    r0 = ras_falls;
    access(1, 3, 1, 8'h11, d, v);
    access(1, 3, 2, 8'h22, d, v);
    access(0, 3, 1, 8'h00, d, v);
    chk(d == 8'h11, "R5 hit read col1", d, 8'h11);
    access(0, 3, 2, 8'h00, d, v);
    chk(d == 8'h22, "R5 hit read col2", d, 8'h22);
    chk(ras_falls == r0, "R5 no row cycle on hits", ras_falls - r0, 0);
  endtask

  task automatic t_miss();
    logic [7:0] d; logic v; int r0;
    r0 = ras_falls;
    access(1, 7, 0, 8'h7E, d, v);
    chk(ras_falls == r0 + 1, "R6 miss reopens row", ras_falls - r0, 1);
    chk(mem[{4'd7, 3'd0}] == 8'h7E, "R6 data at new row", mem[{4'd7, 3'd0}], 8'h7E);
    access(0, 3, 5, 8'h00, d, v);
    chk(d == 8'hA5 && ras_falls == r0 + 2, "R6 back to row3", d, 8'hA5);
    chk(min_bad == 0, "R7 ras low minimum", min_bad, 0);
  endtask

  task automatic t_refresh();
    int f0, n;
    bit seen;
    f0 = refreshes; seen = 0; n = 0;
    @(negedge clk); ref_req = 1;
    while (!seen && n < 200) begin
      @(negedge clk); n++;
      if (ref_gnt) begin seen = 1; ref_req = 0; end
    end
    chk(seen, "R10 grant seen", seen, 1);
    @(negedge clk);
    chk(!ref_gnt, "R10 grant one cycle", ref_gnt, 0);
    repeat (T_RAS_MIN + 4) @(negedge clk);
    chk(refreshes == f0 + 1, "R10 column-before-row refresh", refreshes - f0, 1);
    chk(ras_n && cas_n, "R10 strobes released", {ras_n, cas_n}, 3);
  endtask

  task automatic t_ref_priority();
    logic [7:0] d; logic v;
    bit got_rdy, gnt_first;
    access(1, 2, 4, 8'h5C, d, v);
    @(negedge clk);
    ref_req = 1; req_valid = 1; req_we = 0; req_addr = {4'd2, 3'd4};
    got_rdy = 0; gnt_first = 0;
    for (int i = 0; i < 300 && !got_rdy; i++) begin
      @(negedge clk);
      if (ref_gnt) begin ref_req = 0; if (!got_rdy) gnt_first = 1; end
      if (req_ready) begin got_rdy = 1; d = rd_data; req_valid = 0; end
    end
    chk(gnt_first, "R11 refresh before hit", gnt_first, 1);
    chk(got_rdy && d == 8'h5C, "R11 hit served after refresh", d, 8'h5C);
  endtask

  task automatic t_ras_max();
    logic [7:0] d; logic v; int r0;
    r0 = ras_falls;
    for (int i = 0; i < 60; i++) access(0, 1, i % 8, 8'h00, d, v);
    chk(ras_falls >= r0 + 2, "R9 row forced closed under hits", ras_falls - r0, 2);
    chk(max_bad == 0, "R9 ras low ceiling", max_low, T_RAS_MAX);
    chk(min_bad == 0, "R7 ras low minimum", min_bad, 0);
    chk(rp_bad == 0, "R8 precharge minimum", rp_bad, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << (ROW_W + COL_W)); i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    t_reset();
    rst = 0;
    @(negedge clk);
    t_reset();
    t_write_read();
    t_page_hit();
    t_miss();
    t_refresh();
    t_ref_priority();
    t_ras_max();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule